// File: doc/BRIEF.md
# Register-Driven I2C Slave Controller

This block is a 7-bit-address I2C target that a local processor drives through four small registers. Two flip-flops synchronise SCL and SDA to the system clock. The block finds START and STOP conditions on the synchronised lines and shifts in the calling address. It compares that address with an own-address register. When the address matches, the block acknowledges it, raises an address-hit flag, records the master's read/write intent and pulses an interrupt.

Software answers the interrupt. It reads the status register and selects receive or transmit with a control bit. It then moves each byte through one shared data register. When the block receives, a control bit chooses whether each byte is acknowledged. When the block transmits, it records the master's acknowledge in a status bit. A missing acknowledge makes the block let go of SDA until the next START or STOP. An interrupt pulse marks the end of every nine-clock data slot.

The engine is a state machine with eight states:
- IDLE: the bus is free.
- ADDR: address bits are being shifted in.
- ADDR_ACK: the address acknowledge is driven.
- RX: a data byte is being received.
- RX_ACK: the receive acknowledge slot.
- TX: a data byte is being sent.
- TX_ACK: the master's acknowledge slot.
- IGNORE: the block keeps SDA released until the next START or STOP.

It moves between them as follows:
- A START goes from any state to ADDR.
- A STOP goes from any state to IDLE.
- ADDR goes to ADDR_ACK on a match and to IGNORE on a mismatch.
- ADDR_ACK goes to TX or RX, according to the transmit-enable bit.
- RX goes to RX_ACK, and RX_ACK goes back to RX.
- TX goes to TX_ACK.
- TX_ACK goes to TX when the master acknowledges and to IGNORE when it does not.

Top module: `i2c_slave_ctl`

## Requirements
- R1: After reset, sda_oe and irq are 0 and all four registers read 0.
- R2: The register index is selected by reg_addr, and writes take effect on reg_wr:
  - 0 is control: bit0 is transmit enable and bit1 is "answer not-acknowledge".
  - 1 is status and is read-only: bit0 is address hit, bit1 is master-reads, bit2 is acknowledge seen.
  - 2 is the data register.
  - 3 is the own address in bits 6:0.
- R3: A START (SDA falling while SCL is high) restarts address reception with a cleared bit count and clears the address-hit flag, even in the middle of a byte. A STOP (SDA rising while SCL is high) returns the engine to idle with SDA released.
- R4: The address arrives as 7 bits, MSB first, followed by the R/W bit. On a match the block sets address hit, copies R/W into master-reads and pulses irq on the 8th SCL rise.
- R5: On a match, SDA is driven low from the SCL fall after the 8th rise until the SCL fall after the 9th rise.
- R6: On an address mismatch the block never drives SDA, never pulses irq and never changes the data register until the next START.
- R7: With transmit enable at 0, the 8 data bits are shifted in MSB first and stored in the data register. On the 9th clock SDA is driven low if "answer not-acknowledge" is 0 and is left released if it is 1.
- R8: With transmit enable at 1 at the fall that ends the address slot, the data register is loaded and sent MSB first. SDA changes only on SCL falls and is released for the 9th clock.
- R9: On the 9th SCL rise of a transmit slot, acknowledge seen is set to 1 if SDA is low and to 0 if it is high. After an acknowledge, the next byte is taken from the data register at the following fall. After a not-acknowledge, SDA stays released for all further clocks until START or STOP.
- R10: irq is a one-cycle pulse at the SCL fall that ends each 9-clock data slot, in both receive and transmit.
- R11: Every change on sda_oe and irq appears exactly 3 clock cycles after the SCL or SDA pin edge that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| irq | output | 1 | One-cycle event pulse |
| reg_addr | input | 2 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |

## Verification
The hardest path to reach is the transmit turnaround. Software must see the address interrupt, read master-reads, and write both the data register and transmit enable. All of this has to happen in the high half of the 9th SCL clock, before the fall that starts the first data bit. The bench therefore holds SCL high after the 9th rise and does these register accesses there.

A second byte is queued while the first is still being shifted out. That byte is then ended with a master not-acknowledge, followed by an extra SCL pulse to show that SDA stays released. A restart three bits into an address proves that the bit count is cleared.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } eng_state_t;

    localparam int REG_AW = 2;
    localparam logic [REG_AW-1:0] REG_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] REG_STAT = 2'd1;
    localparam logic [REG_AW-1:0] REG_DATA = 2'd2;
    localparam logic [REG_AW-1:0] REG_OWN  = 2'd3;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise,
    output logic fall
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], pin};
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_lvl,
    input  logic          sda_rise,
    input  logic          sda_fall,
    input  logic [DW-2:0] own_addr,
    input  logic          tx_en,
    input  logic          nack_sel,
    input  logic [DW-1:0] tx_byte,
    output logic          sda_oe,
    output logic          irq,
    output logic          hit,
    output logic          master_reads,
    output logic          ack_seen,
    output logic          rx_load,
    output logic [DW-1:0] rx_byte,
    output eng_state_t    state
);
    localparam int AW = DW - 1;
    localparam int CW = $clog2(DW + 2);
    localparam logic [CW-1:0] C_LAST = CW'(DW - 1);
    localparam logic [CW-1:0] C_ACK  = CW'(DW);
    localparam logic [CW-1:0] C_END  = CW'(DW + 1);

    eng_state_t      st, nxt;
    logic [CW-1:0]   cnt;
    logic [DW-1:0]   shreg;
    logic            start_ev, stop_ev;

    assign start_ev = scl_lvl & sda_fall;
    assign stop_ev  = scl_lvl & sda_rise;
    assign state    = st;
    assign rx_byte  = shreg;

    // next-state decision
    always_comb begin
        nxt = st;
        if (start_ev)      nxt = ST_ADDR;
        else if (stop_ev)  nxt = ST_IDLE;
        else begin
            unique case (st)
                ST_ADDR:     if (scl_rise && cnt == C_LAST)
                                 nxt = (shreg[AW-1:0] == own_addr) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall && cnt == C_END) nxt = tx_en ? ST_TX : ST_RX;
                ST_RX:       if (scl_rise && cnt == C_LAST) nxt = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall && cnt == C_END) nxt = ST_RX;
                ST_TX:       if (scl_fall && cnt == C_ACK) nxt = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall && cnt == C_END) nxt = ack_seen ? ST_TX : ST_IGNORE;
                default:     nxt = st;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt          <= '0;
            shreg        <= '0;
            sda_oe       <= 1'b0;
            irq          <= 1'b0;
            hit          <= 1'b0;
            master_reads <= 1'b0;
            ack_seen     <= 1'b0;
            rx_load      <= 1'b0;
        end else begin
            irq     <= 1'b0;
            rx_load <= 1'b0;
            if (start_ev) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
                hit    <= 1'b0;
            end else if (stop_ev) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR: if (scl_rise) begin
                        shreg <= {shreg[DW-2:0], sda_lvl};
                        cnt   <= cnt + 1'b1;
                        if (cnt == C_LAST && shreg[AW-1:0] == own_addr) begin
                            hit          <= 1'b1;
                            master_reads <= sda_lvl;
                            irq          <= 1'b1;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_rise) cnt <= cnt + 1'b1;
                        if (scl_fall && cnt == C_ACK) sda_oe <= 1'b1;
                        if (scl_fall && cnt == C_END) begin
                            cnt <= '0;
                            if (tx_en) begin
                                sda_oe <= ~tx_byte[DW-1];
                                shreg  <= {tx_byte[DW-2:0], 1'b1};
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RX: if (scl_rise) begin
                        shreg <= {shreg[DW-2:0], sda_lvl};
                        cnt   <= cnt + 1'b1;
                        if (cnt == C_LAST) rx_load <= 1'b1;
                    end
                    ST_RX_ACK: begin
                        if (scl_rise) cnt <= cnt + 1'b1;
                        if (scl_fall && cnt == C_ACK) sda_oe <= ~nack_sel;
                        if (scl_fall && cnt == C_END) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            irq    <= 1'b1;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) cnt <= cnt + 1'b1;
                        if (scl_fall) begin
                            if (cnt == C_ACK) begin
                                sda_oe <= 1'b0;
                            end else begin
                                sda_oe <= ~shreg[DW-1];
                                shreg  <= {shreg[DW-2:0], 1'b1};
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            cnt      <= cnt + 1'b1;
                            ack_seen <= ~sda_lvl;
                        end
                        if (scl_fall && cnt == C_END) begin
                            irq <= 1'b1;
                            cnt <= '0;
                            if (ack_seen) begin
                                sda_oe <= ~tx_byte[DW-1];
                                shreg  <= {tx_byte[DW-2:0], 1'b1};
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_slave_ctl.sv
module i2c_slave_ctl
    import i2cs_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic          irq,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata
);
    localparam int AW = DW - 1;

    logic          scl_lvl, scl_rise, scl_fall;
    logic          sda_lvl, sda_rise, sda_fall;
    logic          ctrl_tx_en, ctrl_nack;
    logic [DW-1:0] data_q;
    logic [AW-1:0] own_q;
    logic          hit, master_reads, ack_seen, rx_load;
    logic [DW-1:0] rx_byte;
    eng_state_t    eng_state;

    i2cs_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(rst_n), .pin(scl_i),
        .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall)
    );

    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(rst_n), .pin(sda_i),
        .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall)
    );

    i2cs_engine #(.DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .own_addr(own_q), .tx_en(ctrl_tx_en), .nack_sel(ctrl_nack),
        .tx_byte(data_q),
        .sda_oe(sda_oe), .irq(irq), .hit(hit), .master_reads(master_reads),
        .ack_seen(ack_seen), .rx_load(rx_load), .rx_byte(rx_byte),
        .state(eng_state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_tx_en <= 1'b0;
            ctrl_nack  <= 1'b0;
            data_q     <= '0;
            own_q      <= '0;
        end else begin
            if (reg_wr && reg_addr == REG_CTRL) begin
                ctrl_tx_en <= reg_wdata[0];
                ctrl_nack  <= reg_wdata[1];
            end
            if (reg_wr && reg_addr == REG_OWN) own_q <= reg_wdata[AW-1:0];
            // a received byte wins over a same-cycle software write
            if (rx_load)                                data_q <= rx_byte;
            else if (reg_wr && reg_addr == REG_DATA)   data_q <= reg_wdata;
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_CTRL: reg_rdata = DW'({ctrl_nack, ctrl_tx_en});
            REG_STAT: reg_rdata = DW'({ack_seen, master_reads, hit});
            REG_DATA: reg_rdata = data_q;
            REG_OWN:  reg_rdata = DW'(own_q);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
    import i2cs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       sda_oe,
    input logic       scl_sync,
    input logic       nack_sel,
    input logic       hit,
    input eng_state_t eng_state
);
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R10

    AST_DRIVE_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_sync); // R8

    AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == ST_IGNORE) |-> !sda_oe); // R6

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == ST_IDLE) |-> !sda_oe); // R3

    AST_NACK_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && eng_state == ST_RX_ACK) |-> !$past(nack_sel)); // R7

    AST_HIT_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> irq); // R4
endmodule

bind i2c_slave_ctl i2cs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .sda_oe(sda_oe),
    .scl_sync(scl_lvl), .nack_sel(ctrl_nack), .hit(hit),
    .eng_state(eng_state)
);

// File: tb/sim_i2c_slave_ctl.sv
module sim_i2c_slave_ctl;
    localparam int HP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       sda_oe, irq;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    i2c_slave_ctl u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .irq(irq), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    ideal_oe = 1'b0;
    bit    ideal_irq = 1'b0;
    bit [2:0] p_oe = '0;
    bit [2:0] p_irq = '0;
    bit    cmp_on = 1'b0;

    // reference response delayed by the 3-cycle pin-to-output latency (R11)
    always @(posedge clk) begin
        p_oe  <= {p_oe[1:0], ideal_oe};
        p_irq <= {p_irq[1:0], ideal_irq};
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            n_chk++;
            if (sda_oe !== p_oe[2] || irq !== p_irq[2]) begin
                n_fail++;
                $display("FAIL %s/R11: oe=%b irq=%b expected oe=%b irq=%b at %0t",
                         cur_req, sda_oe, irq, p_oe[2], p_irq[2], $time);
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
    end

    task automatic set_pins(input bit s, input bit d, input bit eo, input bit iq);
        @(negedge clk);
        scl_m = s;
        sda_m = d;
        ideal_oe = eo;
        ideal_irq = iq;
        @(negedge clk);
        ideal_irq = 1'b0;
        repeat (HP - 2) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, e);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic start_cond();
        set_pins(1'b0, 1'b1, 1'b0, 1'b0);
        set_pins(1'b1, 1'b1, 1'b0, 1'b0);
        set_pins(1'b1, 1'b0, 1'b0, 1'b0);
        set_pins(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic stop_cond();
        set_pins(1'b0, 1'b0, 1'b0, 1'b0);
        set_pins(1'b1, 1'b0, 1'b0, 1'b0);
        set_pins(1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    // master sends 8 bits; ends with SCL high on the 9th clock
    task automatic m_byte(input logic [7:0] b, input bit ack, input bit irq8);
        for (int i = 7; i >= 0; i--) begin
            set_pins(1'b0, b[i], 1'b0, 1'b0);
            set_pins(1'b1, b[i], 1'b0, (i == 0) && irq8);
        end
        set_pins(1'b0, 1'b1, ack, 1'b0);
        set_pins(1'b1, 1'b1, ack, 1'b0);
    endtask

    // slave sends d (first bit already driven); ends with SCL high on the 9th clock
    task automatic s_byte(input logic [7:0] d, input bit mack);
        logic [7:0] t = d;
        for (int k = 0; k < 8; k++) begin
            set_pins(1'b1, 1'b1, ~t[7], 1'b0);
            t = t << 1;
            set_pins(1'b0, 1'b1, (k < 7) ? ~t[7] : 1'b0, 1'b0);
        end
        set_pins(1'b0, ~mack, 1'b0, 1'b0);
        set_pins(1'b1, ~mack, 1'b0, 1'b0);
    endtask

    task automatic fall(input bit eo, input bit iq);
        set_pins(1'b0, 1'b1, eo, iq);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, 8'h00, "R1");
        rd(2'd1, 8'h00, "R1");
        rd(2'd2, 8'h00, "R1");
        rd(2'd3, 8'h00, "R1");
        // R2 register map
        wr(2'd3, 8'h2A);
        rd(2'd3, 8'h2A, "R2");
        wr(2'd0, 8'h03);
        rd(2'd0, 8'h03, "R2");
        wr(2'd1, 8'hFF);
        rd(2'd1, 8'h00, "R2");
        wr(2'd0, 8'h00);

        // write transfer: address 0x2A, W
        cur_req = "R4";
        start_cond();
        m_byte(8'h54, 1'b1, 1'b1);
        rd(2'd1, 8'h01, "R4");
        cur_req = "R5";
        fall(1'b0, 1'b0);
        cur_req = "R7";
        m_byte(8'hA5, 1'b1, 1'b0);
        cur_req = "R10";
        fall(1'b0, 1'b1);
        rd(2'd2, 8'hA5, "R7");
        wr(2'd0, 8'h02);
        cur_req = "R7";
        m_byte(8'h3C, 1'b0, 1'b0);
        fall(1'b0, 1'b1);
        rd(2'd2, 8'h3C, "R7");
        wr(2'd0, 8'h00);

        // repeated start with a foreign address
        cur_req = "R6";
        start_cond();
        m_byte(8'h56, 1'b0, 1'b0);
        rd(2'd1, 8'h00, "R3");
        fall(1'b0, 1'b0);
        m_byte(8'h99, 1'b0, 1'b0);
        fall(1'b0, 1'b0);
        rd(2'd2, 8'h3C, "R6");
        stop_cond();

        // read transfer: address 0x2A, R
        cur_req = "R8";
        start_cond();
        m_byte(8'h55, 1'b1, 1'b1);
        rd(2'd1, 8'h03, "R4");
        wr(2'd2, 8'hC3);
        wr(2'd0, 8'h01);
        fall(1'b0, 1'b0);
        s_byte(8'hC3, 1'b1);
        wr(2'd2, 8'h5A);
        cur_req = "R9";
        fall(1'b1, 1'b1);
        rd(2'd1, 8'h07, "R9");
        cur_req = "R8";
        s_byte(8'h5A, 1'b0);
        cur_req = "R10";
        fall(1'b0, 1'b1);
        rd(2'd1, 8'h03, "R9");
        cur_req = "R9";
        set_pins(1'b1, 1'b1, 1'b0, 1'b0);
        set_pins(1'b0, 1'b1, 1'b0, 1'b0);
        cur_req = "R3";
        stop_cond();

        // restart three bits into an address
        wr(2'd0, 8'h00);
        cur_req = "R3";
        start_cond();
        for (int i = 7; i >= 5; i--) begin
            set_pins(1'b0, 1'b1, 1'b0, 1'b0);
            set_pins(1'b1, 1'b1, 1'b0, 1'b0);
        end
        start_cond();
        m_byte(8'h54, 1'b1, 1'b1);
        rd(2'd1, 8'h01, "R3");
        fall(1'b0, 1'b0);
        stop_cond();
        repeat (6) @(negedge clk);
        summary();
    end
endmodule